// File: doc/BRIEF.md
# Differential SAR Converter Serial Interface Controller

This block is the master side of a three-wire link to a successive-approximation converter: a convert-start output, a generated serial clock and a serial data input. On a host start request it raises convert-start to ready the converter. It then drops the line, and that falling edge is the sampling instant and starts the conversion. A burst of serial clocks follows. The converter needs these clocks to make progress, and it shifts its result out on them. The controller collects the 10-bit result, most significant bit first, and presents it on a parallel port with a one-cycle valid strobe.

The converter's track-and-hold returns to tracking on the fourteenth serial-clock rising edge of a frame. The controller times a minimum acquisition interval from that edge. It holds convert-start high until that interval has passed, so the next sampling edge is never too early. The interval is a time in picoseconds, turned into system-clock cycles through the clock-period parameter. The serial clock runs at the system clock divided by an even factor. A parameter gives the clock index of the first result bit within the 14-clock frame. The bits on all other clocks are discarded.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, busy_o, cnv_o, sclk_o and valid_o are low. The first conversion needs no acquisition wait: its cnv_o falling edge comes exactly CNV_HIGH cycles after the start is accepted.
- R2: A start_i sampled high while busy_o is low is accepted on that edge. busy_o and cnv_o are high from that edge on, and cnv_o stays high for at least CNV_HIGH cycles.
- R3: cnv_o falls on edge max(Es + CNV_HIGH, E14 + ACQ_CYC). Es is the edge that accepted the start. E14 is the edge that produced the previous frame's fourteenth sclk_o rise. ACQ_CYC = ceil(ACQ_MIN_PS / CLK_PERIOD_PS), which is 26 at the defaults.
- R4: sclk_o is low whenever cnv_o is high and whenever busy_o is low. A frame has exactly FRAME_CLKS rising edges with a period of SCLK_DIV cycles: each clock is low for SCLK_DIV/2 cycles, then high for SCLK_DIV/2 cycles. The first rise comes SCLK_DIV/2 cycles after the cnv_o fall.
- R5: sdata_i is sampled on the edge where sclk_o falls. Clocks are numbered from 0, starting with the first clock after the cnv_o fall. The bit captured on clock FIRST_BIT becomes result bit DATA_W-1, and the next bits fill the lower bits in order. Bits on clocks outside FIRST_BIT..FIRST_BIT+DATA_W-1 are ignored.
- R6: valid_o is high for exactly one cycle, on edge Ef + FRAME_CLKS*SCLK_DIV, where Ef is the edge of the cnv_o fall. busy_o drops on that same edge. result_o changes only on an edge where valid_o rises, and it holds its value until the next one.
- R7: A start_i while busy_o is high is ignored. Every accepted start gives exactly one valid_o pulse.
- R8: No cnv_o fall comes earlier than ACQ_CYC cycles after the previous frame's fourteenth sclk_o rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host conversion request, sampled while idle |
| busy_o | output | 1 | High from start acceptance to end of frame |
| result_o | output | DATA_W | Last conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| cnv_o | output | 1 | Convert-start to converter; falling edge samples |
| sclk_o | output | 1 | Serial clock to converter |
| sdata_i | input | 1 | Serial data from converter, updated on sclk_o rise |

## Verification
All timing is counted in clock edges from the start-accept edge Es. cnv_o rises on Es, and falls on the later of Es+CNV_HIGH and the previous fourteenth-rise edge plus ACQ_CYC. The first sclk_o rise is due SCLK_DIV/2 edges after that fall, and valid_o with the result is due FRAME_CLKS*SCLK_DIV edges after it. The bench keeps a free-running edge counter and samples every output on the falling clock edge, so the values it reads are settled values after an edge. It compares each event's edge number with the value predicted by its own functions, instead of waiting an open-ended time for an event. A converter model drives result bits on sclk_o rises and random filler bits on the other clocks, which shows that the capture window is placed correctly.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_FRAME = 2'd2
  } ctrl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int SCLK_DIV   = 4,
  parameter int FRAME_CLKS = 14,
  localparam int PH_W      = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1,
  localparam int IDX_W     = $clog2(FRAME_CLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             last_rise_o,
  output logic             last_fall_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam int HALF = SCLK_DIV / 2;

  logic [PH_W-1:0]  ph_q;
  logic [IDX_W-1:0] idx_q;
  logic             ph_end, ph_mid, idx_last;

  assign ph_end   = (ph_q == PH_W'(SCLK_DIV - 1));
  assign ph_mid   = (ph_q == PH_W'(HALF - 1));
  assign idx_last = (idx_q == IDX_W'(FRAME_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      idx_q <= '0;
    end else if (!run_i) begin
      ph_q  <= '0;
      idx_q <= '0;
    end else if (ph_end) begin
      ph_q  <= '0;
      idx_q <= idx_q + 1'b1;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  // low half first, so the first rise trails the sampling edge
  assign sclk_o      = run_i && (ph_q >= PH_W'(HALF));
  assign fall_o      = run_i && ph_end;
  assign last_rise_o = run_i && ph_mid && idx_last;
  assign last_fall_o = run_i && ph_end && idx_last;
  assign idx_o       = idx_q;

endmodule

// File: rtl/sar_shift_rx.sv
module sar_shift_rx #(
  parameter int DATA_W     = 10,
  parameter int FRAME_CLKS = 14,
  parameter int FIRST_BIT  = 1,
  localparam int IDX_W     = $clog2(FRAME_CLKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);

  localparam int LAST_BIT = FIRST_BIT + DATA_W - 1;

  logic              lo_ok, hi_ok, cap;
  logic [DATA_W-1:0] sh_q, sh_nx;

  generate
    if (FIRST_BIT == 0) begin : g_lo_open
      assign lo_ok = 1'b1;
    end else begin : g_lo_cmp
      assign lo_ok = (idx_i >= IDX_W'(FIRST_BIT));
    end
    if (LAST_BIT >= FRAME_CLKS - 1) begin : g_hi_open
      assign hi_ok = 1'b1;
    end else begin : g_hi_cmp
      assign hi_ok = (idx_i <= IDX_W'(LAST_BIT));
    end
  endgenerate

  assign cap   = fall_i && lo_ok && hi_ok;
  assign sh_nx = {sh_q[DATA_W-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (cap) sh_q <= sh_nx;
      // last result bit may land on the frame's final clock
      if (last_i) result_o <= cap ? sh_nx : sh_q;
      valid_o <= last_i;
    end
  end

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
  parameter int ACQ_CYC = 26,
  localparam int CNT_W  = $clog2(ACQ_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(ACQ_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // ready one cycle early: the sampling edge itself is the ACQ_CYC-th edge
  assign ready_o = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int DATA_W        = 10,
  parameter int FRAME_CLKS    = 14,
  parameter int FIRST_BIT     = 1,
  parameter int SCLK_DIV      = 4,
  parameter int CNV_HIGH      = 4,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int ACQ_MIN_PS    = 104000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              cnv_o,
  output logic              sclk_o,
  input  logic              sdata_i
);

  import sar_adc_pkg::*;

  localparam int ACQ_RAW = ceil_div(ACQ_MIN_PS, CLK_PERIOD_PS);
  localparam int ACQ_CYC = (ACQ_RAW < 1) ? 1 : ACQ_RAW;
  localparam int HI_W    = $clog2(CNV_HIGH + 1);
  localparam int IDX_W   = $clog2(FRAME_CLKS);

  ctrl_state_e      state_q, state_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             run, fall, last_rise, last_fall, acq_ready;
  logic [IDX_W-1:0] idx;

  assign run = (state_q == ST_FRAME);

  always_comb begin
    state_d = state_q;
    hi_d    = hi_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ARM;
          hi_d    = HI_W'(CNV_HIGH - 1);
        end
      end
      ST_ARM: begin
        if (hi_q != '0) hi_d = hi_q - 1'b1;
        if (hi_q == '0 && acq_ready) state_d = ST_FRAME;
      end
      ST_FRAME: begin
        if (last_fall) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign cnv_o  = (state_q == ST_ARM);

  sar_sclk_gen #(
    .SCLK_DIV  (SCLK_DIV),
    .FRAME_CLKS(FRAME_CLKS)
  ) u_sclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .sclk_o     (sclk_o),
    .fall_o     (fall),
    .last_rise_o(last_rise),
    .last_fall_o(last_fall),
    .idx_o      (idx)
  );

  sar_shift_rx #(
    .DATA_W    (DATA_W),
    .FRAME_CLKS(FRAME_CLKS),
    .FIRST_BIT (FIRST_BIT)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall),
    .last_i  (last_fall),
    .idx_i   (idx),
    .sdata_i (sdata_i),
    .result_o(result_o),
    .valid_o (valid_o)
  );

  sar_acq_timer #(
    .ACQ_CYC(ACQ_CYC)
  ) u_acq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (last_rise),
    .ready_o(acq_ready)
  );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int DATA_W     = 10,
  parameter int FRAME_CLKS = 14,
  parameter int CNV_HIGH   = 4,
  parameter int ACQ_CYC    = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              cnv_o,
  input logic              sclk_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);

  logic        sclk_q;
  logic [15:0] rise_cnt, gap_cnt, hi_len;
  logic        sclk_up;

  assign sclk_up = sclk_o && !sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
      gap_cnt  <= '1;
      hi_len   <= '0;
    end else begin
      sclk_q <= sclk_o;
      if (cnv_o) rise_cnt <= '0;
      else if (sclk_up && rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
      if (sclk_up && rise_cnt == 16'(FRAME_CLKS - 1)) gap_cnt <= 16'd1;
      else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
      if (!cnv_o) hi_len <= '0;
      else if (hi_len != '1) hi_len <= hi_len + 1'b1;
    end
  end

  assert_cnv_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_o) |-> (hi_len >= 16'(CNV_HIGH)));

  assert_sclk_quiet_cnv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_o |-> !sclk_o);

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cnv_o && !sclk_o));

  assert_frame_rises_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rise_cnt == 16'(FRAME_CLKS)));

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_ends_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);

  assert_valid_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);

  assert_result_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> valid_o);

  assert_acq_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_o) |-> (gap_cnt >= 16'(ACQ_CYC)));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
  .DATA_W    (DATA_W),
  .FRAME_CLKS(FRAME_CLKS),
  .CNV_HIGH  (CNV_HIGH),
  .ACQ_CYC   (ACQ_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .cnv_o   (cnv_o),
  .sclk_o  (sclk_o),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;

  localparam int DW      = 10;
  localparam int FRAME   = 14;
  localparam int FB      = 1;
  localparam int DIV     = 4;
  localparam int HALF    = DIV / 2;
  localparam int CNV_HI  = 4;
  localparam int CLK_PS  = 4000;
  localparam int ACQ_PS  = 104000;
  localparam int ACQ     = (ACQ_PS + CLK_PS - 1) / CLK_PS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sdata = 1'b0;
  logic          busy, valid, cnv, sclk;
  logic [DW-1:0] result;

  sar_adc_ctrl #(
    .DATA_W(DW), .FRAME_CLKS(FRAME), .FIRST_BIT(FB), .SCLK_DIV(DIV),
    .CNV_HIGH(CNV_HI), .CLK_PERIOD_PS(CLK_PS), .ACQ_MIN_PS(ACQ_PS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy),
    .result_o(result), .valid_o(valid), .cnv_o(cnv), .sclk_o(sclk),
    .sdata_i(sdata)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_fall(input int es_, input int e14_, input bit have);
    int t = es_ + CNV_HI;
    if (have && e14_ + ACQ > t) t = e14_ + ACQ;
    return t;
  endfunction

  function automatic int exp_valid(input int ef_);
    return ef_ + FRAME * DIV;
  endfunction

  // converter model: new bit on each sclk rise, filler outside the result window
  logic [DW-1:0] next_word = '0, cur_word = '0;
  int mcnt = 0;
  always @(posedge cnv) begin
    cur_word = next_word;
    mcnt = 0;
  end
  always @(posedge sclk) begin
    if (mcnt >= FB && mcnt < FB + DW) sdata <= cur_word[DW-1-(mcnt-FB)];
    else sdata <= 1'($urandom % 2);
    mcnt++;
  end

  // monitor, sampled away from the active edge
  logic pb = 1'b0, pc = 1'b0, ps = 1'b0;
  logic [DW-1:0] last_res = '0;
  int es = 0, ef = 0, e14 = 0, rises = 0, n_valid = 0, n_acc = 0, n_conv = 0;
  bit have14 = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !pb) begin
        es = cyc;
        check(cnv == 1'b1, "R2 cnv high on accept", int'(cnv), 1);
      end
      if (cnv && sclk) check(1'b0, "R4 sclk during cnv", 1, 0);
      if (!busy && (cnv || sclk)) check(1'b0, "R4 lines quiet when idle", int'({cnv, sclk}), 0);
      if (!cnv && pc) begin
        ef = cyc;
        n_conv++;
        if (n_conv == 1) check(ef == es + CNV_HI, "R1 first sample without wait", ef - es, CNV_HI);
        check(ef == exp_fall(es, e14, have14), "R3 sampling edge", ef, exp_fall(es, e14, have14));
        check(ef - es >= CNV_HI, "R2 cnv min high", ef - es, CNV_HI);
        if (have14) check(ef - e14 >= ACQ, "R8 acquisition gap", ef - e14, ACQ);
        rises = 0;
      end
      if (sclk && !ps) begin
        rises++;
        if (rises == 1) check(cyc == ef + HALF, "R4 first rise", cyc - ef, HALF);
        if (rises > 1) check(cyc == ef + HALF + (rises - 1) * DIV, "R4 sclk period", cyc - ef, HALF + (rises - 1) * DIV);
        if (rises == FRAME) begin
          e14 = cyc;
          have14 = 1'b1;
        end
      end
      if (valid) begin
        n_valid++;
        check(cyc == exp_valid(ef), "R6 valid timing", cyc, exp_valid(ef));
        check(!busy, "R6 busy drops with valid", int'(busy), 0);
        check(result == cur_word, "R5 result", int'(result), int'(cur_word));
        check(rises == FRAME, "R4 rises per frame", rises, FRAME);
        last_res = result;
      end else if (result != last_res) begin
        check(1'b0, "R6 result held", int'(result), int'(last_res));
        last_res = result;
      end
      if (valid && pb == 1'b0) check(1'b0, "R6 valid without frame", 1, 0);
    end
    pb = busy;
    pc = cnv;
    ps = sclk;
  end

  task automatic conv(input logic [DW-1:0] word, input int gap, input bit poke);
    int target;
    repeat (gap) @(negedge clk);
    while (busy) @(negedge clk);
    next_word = word;
    start = 1'b1;
    n_acc++;
    target = n_acc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (1 + ($urandom % 50)) @(negedge clk);
      if (busy) begin
        start = 1'b1;       // R7: must be ignored
        @(negedge clk);
        start = 1'b0;
      end
    end
    while (n_valid < target) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, cnv, sclk, valid} == 4'b0, "R1 reset state", int'({busy, cnv, sclk, valid}), 0);
    check(result == '0, "R1 reset result", int'(result), 0);
    conv('0, 0, 1'b0);
    conv('1, 0, 1'b0);
    conv(10'h200, 3, 1'b1);
    conv(10'h001, 0, 1'b1);
    conv(10'h155, 40, 1'b0);
    for (int i = 0; i < 60; i++)
      conv(DW'($urandom), $urandom % 40, 1'($urandom % 2));
    repeat (20) @(negedge clk);
    check(n_valid == n_acc, "R7 one result per accepted start", n_valid, n_acc);
    check(!busy && !valid, "R7 idle after last frame", int'({busy, valid}), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_valid, n_acc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule